// File: doc/BRIEF.md
# Binary n-Cube Message Router Node

This block holds the routing logic of one node in a binary n-cube network of 2^n nodes. The node has a fixed n-bit address, set by a parameter, and one bidirectional link per dimension. Each neighbour's address differs from the node's address in exactly one bit, and the position of that bit names the link between them. Messages enter on the local injection port or on any of the n incoming link ports. Each message is a destination address plus a payload word. Every port uses a valid/ready handshake.

For each message, the node takes the exclusive-OR of its own address and the destination address. If the result is zero, the message has arrived and goes to the local delivery port. Otherwise the message leaves on the link of the lowest-numbered set bit. This routes in dimension order, so a path takes between one and n hops. Every output port has a single register slot. When several inputs want the same output in one cycle, a round-robin arbiter picks one of them, and each losing input sees ready low until it is chosen.

Input and output ports are both numbered with index 0 as the local port and index d+1 as the link of dimension d. The address and payload buses are flat, and port p occupies slice p.

Top module: `hypercube_node`

## Requirements
- R1: A message whose destination equals NODE_ADDR appears on output port 0 (local delivery).
- R2: A message with a non-zero XOR of destination and NODE_ADDR appears on output port d+1, where d is the lowest set bit of that XOR.
- R3: The destination and the payload leave the node exactly as they entered.
- R4: A message accepted at a clock edge (valid and ready both high) is valid at its output port right after that same edge.
- R5: While an output holds valid high and its ready is low, its valid, destination and payload stay unchanged.
- R6: When several inputs request one output, exactly one of them receives ready. The winner is the first requester at or after a rotating pointer. After a grant the pointer moves to the winner's index plus one, wrapping, and reset sets it to 0.
- R7: Inputs that target different outputs are all accepted in the same cycle.
- R8: After reset, every output valid is low.
- R9: An input whose target output is full and not drained in that cycle sees ready low. When the output's ready rises, the input is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | DIM+1 | Per-input message valid (0 local, d+1 link d) |
| in_ready | output | DIM+1 | Per-input acceptance |
| in_dest | input | (DIM+1)*DIM | Destination address per input |
| in_data | input | (DIM+1)*PW | Payload per input |
| out_valid | output | DIM+1 | Per-output message valid (0 delivery, d+1 link d) |
| out_ready | input | DIM+1 | Per-output downstream ready |
| out_dest | output | (DIM+1)*DIM | Destination address per output |
| out_data | output | (DIM+1)*PW | Payload per output |

## Verification
A wrong route selection shows up one cycle after acceptance, as the message appearing on the wrong output index. A corrupted round-robin pointer shows up at the in_ready pattern within the first contended cycle. A broken full-slot condition shows up in two ways: a held output changes its payload while ready is low, or an input is acknowledged while its output is blocked. Both are visible in the cycle it happens. The vector table walks XOR patterns with single and multiple set bits on every input port. Directed cases then cover contention, backpressure and parallel traffic.

// File: rtl/hypercube_node.sv
module hypercube_node #(
  parameter int DIM = 3,
  parameter int PW = 8,
  parameter logic [DIM-1:0] NODE_ADDR = 3'b101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIM:0]            in_valid,
  output logic [DIM:0]            in_ready,
  input  logic [(DIM+1)*DIM-1:0]  in_dest,
  input  logic [(DIM+1)*PW-1:0]   in_data,
  output logic [DIM:0]            out_valid,
  input  logic [DIM:0]            out_ready,
  output logic [(DIM+1)*DIM-1:0]  out_dest,
  output logic [(DIM+1)*PW-1:0]   out_data
);
  localparam int NP = DIM + 1;
  localparam int PTRW = (NP > 1) ? $clog2(NP) : 1;

  logic [PTRW-1:0] sel [NP];
  logic [NP-1:0]   req [NP];
  logic [NP-1:0]   gnt [NP];
  logic [PTRW-1:0] win [NP];
  logic [PTRW-1:0] ptr [NP];
  logic [NP-1:0]   take;
  logic [DIM-1:0]  nxt_dest [NP];
  logic [PW-1:0]   nxt_data [NP];
  logic [DIM-1:0]  od [NP];
  logic [PW-1:0]   opl [NP];
  logic [NP-1:0]   ov;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic [DIM-1:0] diff;
      diff = in_dest[i*DIM +: DIM] ^ NODE_ADDR;
      sel[i] = '0;
      for (int d = DIM - 1; d >= 0; d--)
        if (diff[d]) sel[i] = PTRW'(d + 1);
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = in_valid[i] && (sel[i] == PTRW'(o));
  end

  assign take = ~ov | out_ready;

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      logic found;
      found = 1'b0;
      gnt[o] = '0;
      win[o] = '0;
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = int'(ptr[o]) + k;
        if (idx >= NP) idx = idx - NP;
        if (!found && req[o][idx] && take[o]) begin
          found = 1'b1;
          gnt[o][idx] = 1'b1;
          win[o] = PTRW'(idx);
        end
      end
      nxt_dest[o] = '0;
      nxt_data[o] = '0;
      for (int i = 0; i < NP; i++)
        if (gnt[o][i]) begin
          nxt_dest[o] = nxt_dest[o] | in_dest[i*DIM +: DIM];
          nxt_data[o] = nxt_data[o] | in_data[i*PW +: PW];
        end
    end
    for (int i = 0; i < NP; i++) begin
      in_ready[i] = 1'b0;
      for (int o = 0; o < NP; o++)
        in_ready[i] = in_ready[i] | gnt[o][i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov <= '0;
      for (int o = 0; o < NP; o++) begin
        ptr[o] <= '0;
        od[o]  <= '0;
        opl[o] <= '0;
      end
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (|gnt[o]) begin
          ov[o]  <= 1'b1;
          od[o]  <= nxt_dest[o];
          opl[o] <= nxt_data[o];
          ptr[o] <= (int'(win[o]) == NP - 1) ? '0 : win[o] + 1'b1;
        end else if (out_ready[o]) begin
          ov[o] <= 1'b0;
        end
      end
    end
  end

  assign out_valid = ov;

  generate
    for (genvar o = 0; o < NP; o++) begin : g_out
      assign out_dest[o*DIM +: DIM] = od[o];
      assign out_data[o*PW +: PW]   = opl[o];

      // R5
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_dest[o*DIM +: DIM])
                                          && $stable(out_data[o*PW +: PW]));
      // R9
      full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] && !out_ready[o] |-> gnt[o] == '0);
      // R6
      one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt[o]));

      if (o == 0) begin : g_loc
        // R1
        local_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid[0] |-> out_dest[DIM-1:0] == NODE_ADDR);
      end else begin : g_link
        localparam logic [DIM-1:0] BIT = DIM'(1) << (o - 1);
        // R2
        link_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid[o] |-> ((out_dest[o*DIM +: DIM] ^ NODE_ADDR) & ((BIT << 1) - 1'b1)) == BIT);
      end
    end

    for (genvar i = 0; i < NP; i++) begin : g_in
      // R4
      accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[i] && in_ready[i] |=> out_valid[$past(sel[i])]);
    end
  endgenerate
endmodule

// File: tb/hypercube_node_test.sv
module hypercube_node_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 3;
  localparam int PW = 8;
  localparam int NP = DIM + 1;
  localparam logic [DIM-1:0] ME = 3'b101;

  // {src[1:0], dest[2:0], data[7:0], expected out port[1:0]}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 3'b101, 8'h11, 2'd0},
    {2'd0, 3'b100, 8'h22, 2'd1},
    {2'd1, 3'b111, 8'h33, 2'd2},
    {2'd2, 3'b001, 8'h44, 2'd3},
    {2'd3, 3'b110, 8'h55, 2'd1},
    {2'd0, 3'b000, 8'h66, 2'd1},
    {2'd2, 3'b101, 8'h77, 2'd0},
    {2'd1, 3'b011, 8'h88, 2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [NP*DIM-1:0] in_dest = '0, out_dest;
  logic [NP*PW-1:0] in_data = '0, out_data;
  int n_chk = 0, n_bad = 0;

  hypercube_node #(.DIM(DIM), .PW(PW), .NODE_ADDR(ME)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int s, input logic [DIM-1:0] d, input logic [PW-1:0] v);
    in_valid[s] = 1'b1;
    in_dest[s*DIM +: DIM] = d;
    in_data[s*PW +: PW] = v;
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = '0; out_ready = '1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [PW-1:0] rr_data [NP];
    do_reset();
    // R8 reset state
    chk(out_valid == '0, "R8 out_valid after reset", out_valid, 0);
    chk(in_ready == '0, "R8 in_ready idle", in_ready, 0);

    for (int k = 0; k < NV; k++) begin
      int s, e;
      logic [DIM-1:0] d;
      logic [PW-1:0] v;
      s = int'(VEC[k][14:13]); d = VEC[k][12:10]; v = VEC[k][9:2]; e = int'(VEC[k][1:0]);
      put(s, d, v);
      #1;
      chk(in_ready[s], "R7 single accept", in_ready, 1 << s);
      @(posedge clk); @(negedge clk);
      in_valid = '0;
      // R1 R2 R4 port choice after one edge
      chk(out_valid == NP'(1 << e), e == 0 ? "R1 local port" : "R2 link port", out_valid, 1 << e);
      // R3 unchanged fields
      chk(out_data[e*PW +: PW] == v, "R3 payload", out_data[e*PW +: PW], v);
      chk(out_dest[e*DIM +: DIM] == d, "R3 dest", out_dest[e*DIM +: DIM], d);
    end

    // R6 round robin from pointer 0
    do_reset();
    rr_data[1] = 8'hA1; rr_data[2] = 8'hA2; rr_data[3] = 8'hA3;
    for (int s = 1; s < NP; s++) put(s, ME, rr_data[s]);
    for (int w = 1; w < NP; w++) begin
      #1;
      chk(in_ready == NP'(1 << w), "R6 grant order", in_ready, 1 << w);
      @(posedge clk); @(negedge clk);
      chk(out_valid[0] && out_data[PW-1:0] == rr_data[w], "R6 winner data", out_data[PW-1:0], rr_data[w]);
      in_valid[w] = 1'b0;
    end
    // R6 pointer wrapped to 0: input 0 beats input 3
    @(negedge clk);
    put(0, ME, 8'hB0); put(3, ME, 8'hB3);
    #1;
    chk(in_ready == 4'b0001, "R6 wrap grant", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_valid[0] = 1'b0;
    #1;
    chk(in_ready == 4'b1000, "R6 next grant", in_ready, 8);
    @(posedge clk); @(negedge clk);
    in_valid = '0;
    chk(out_data[PW-1:0] == 8'hB3, "R6 second winner data", out_data[PW-1:0], 8'hB3);

    // R5 R9 backpressure on link dim 0
    @(negedge clk);
    out_ready = 4'b1101;
    put(0, 3'b100, 8'hC0);
    @(posedge clk); @(negedge clk);
    in_valid = '0;
    chk(out_valid[1] && out_data[PW +: PW] == 8'hC0, "R4 stalled slot loaded", out_data[PW +: PW], 8'hC0);
    put(1, 3'b100, 8'hC1);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!in_ready[1], "R9 blocked input", in_ready[1], 0);
      @(posedge clk); @(negedge clk);
      chk(out_valid[1] && out_data[PW +: PW] == 8'hC0, "R5 held payload", out_data[PW +: PW], 8'hC0);
    end
    out_ready = '1;
    #1;
    chk(in_ready[1], "R9 drain and refill", in_ready[1], 1);
    @(posedge clk); @(negedge clk);
    in_valid = '0;
    chk(out_valid[1] && out_data[PW +: PW] == 8'hC1, "R9 refill data", out_data[PW +: PW], 8'hC1);

    // R7 parallel traffic to ports 0, 2, 3
    @(negedge clk);
    put(0, 3'b101, 8'hD0); put(1, 3'b111, 8'hD1); put(2, 3'b001, 8'hD2);
    #1;
    chk(in_ready == 4'b0111, "R7 parallel accept", in_ready, 7);
    @(posedge clk); @(negedge clk);
    in_valid = '0;
    chk(out_valid == 4'b1101, "R7 parallel outputs", out_valid, 13);
    chk(out_data[0 +: PW] == 8'hD0 && out_data[2*PW +: PW] == 8'hD1 && out_data[3*PW +: PW] == 8'hD2,
        "R7 parallel data", out_data, 0);
    @(posedge clk); @(negedge clk);
    chk(out_valid == '0, "R4 drained", out_valid, 0);

    finish_run();
  end
endmodule